// File: doc/BRIEF.md
# Saturating-Counter Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2^K small up/down counters. The low K bits of a branch address select one counter directly. A fetch-side lookup reads the selected counter and answers taken or not-taken within the same cycle. A resolve-side update arrives later, carrying the branch address and its real outcome. It moves the selected counter one step toward that outcome and stops at either end of the counter's range.

Entries carry no tags. Two branches whose addresses agree in the low K bits therefore share one counter and steer each other's predictions. The index width K and the counter width n are parameters. The threshold is half the counter range, so the counter's top bit is the prediction. With two-bit counters, a branch that closes a loop is mispredicted only at the loop exit, once per pass through the loop.

Top module: `sat_ctr_predictor`

## Requirements
- R1: The entry is selected by bits [IDX_W-1:0] of the address alone. Two addresses that differ only above those bits read and update the same counter.
- R2: lookup_taken_o is 1 exactly when the selected counter is at least 2^(CTR_W-1).
- R3: After reset, every counter holds 2^(CTR_W-1)-1, so every lookup predicts not-taken. A single taken update then makes that entry predict taken.
- R4: A valid update with upd_taken_i=1 adds one to the counter. The counter stays at 2^CTR_W-1 once it is there.
- R5: A valid update with upd_taken_i=0 subtracts one from the counter. The counter stays at 0 once it is there.
- R6: When upd_valid_i is 0, no counter changes, whatever upd_addr_i and upd_taken_i hold.
- R7: The lookup is combinational. When a lookup and an update select the same entry in the same cycle, the lookup returns the value from before the update. The new value becomes visible after that clock edge.
- R8: An update changes only the counter that its own index selects.
- R9: With CTR_W=2, a branch that is taken four times and then not taken once, repeated, is mispredicted exactly once per pass after the first pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_addr_i | input | ADDR_W | Address of the branch being predicted |
| lookup_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Apply an update at the next clock edge |
| upd_addr_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
The prediction is due in the same cycle that lookup_addr_i is applied. An update shows at the output only in the cycle after the edge that writes it. The bench drives inputs on the falling edge and compares the prediction 1 ns later against a reference table. It advances that table only after the following rising edge. Because the comparison happens before the reference table moves, a same-index lookup and update in one cycle is checked against the old counter value. The new value is checked on the next lookup.

// File: rtl/sat_pred_pkg.sv
package sat_pred_pkg;
  typedef enum logic {
    DIR_NOT_TAKEN = 1'b0,
    DIR_TAKEN     = 1'b1
  } dir_e;
endpackage

// File: rtl/sat_ctr_step.sv
module sat_ctr_step #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0]  ctr_i,
  input  sat_pred_pkg::dir_e dir_i,
  output logic [CTR_W-1:0]  ctr_o
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  localparam logic [CTR_W-1:0] CTR_MIN = '0;

  always_comb begin
    ctr_o = ctr_i;
    if (dir_i == sat_pred_pkg::DIR_TAKEN) begin
      if (ctr_i != CTR_MAX) ctr_o = ctr_i + CTR_W'(1);
    end else begin
      if (ctr_i != CTR_MIN) ctr_o = ctr_i - CTR_W'(1);
    end
  end
endmodule

// File: rtl/sat_ctr_bank.sv
module sat_ctr_bank #(
  parameter int IDX_W = 6,
  parameter int CTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [CTR_W-1:0] rd_a_ctr_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [CTR_W-1:0] rd_b_ctr_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [CTR_W-1:0] wr_ctr_i
);
  localparam int ENTRIES = 1 << IDX_W;
  // weakly not-taken: one below the threshold
  localparam logic [CTR_W-1:0] CTR_RST = CTR_W'((1 << (CTR_W - 1)) - 1);

  logic [CTR_W-1:0] ctr_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ctr_q[e] <= CTR_RST;
      else if (wr_en_i && wr_idx_i == IDX_W'(e))   ctr_q[e] <= wr_ctr_i;
    end
  end

  assign rd_a_ctr_o = ctr_q[rd_a_idx_i];
  assign rd_b_ctr_o = ctr_q[rd_b_idx_i];
endmodule

// File: rtl/sat_ctr_predictor.sv
module sat_ctr_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] lookup_addr_i,
  output logic              lookup_taken_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic              upd_taken_i
);
  logic [IDX_W-1:0] lkp_idx, upd_idx;
  logic [CTR_W-1:0] rd_ctr, old_ctr, new_ctr;
  sat_pred_pkg::dir_e upd_dir;

  assign lkp_idx = lookup_addr_i[IDX_W-1:0];
  assign upd_idx = upd_addr_i[IDX_W-1:0];
  assign upd_dir = upd_taken_i ? sat_pred_pkg::DIR_TAKEN : sat_pred_pkg::DIR_NOT_TAKEN;

  sat_ctr_bank #(.IDX_W(IDX_W), .CTR_W(CTR_W)) i_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_a_idx_i (lkp_idx),
    .rd_a_ctr_o (rd_ctr),
    .rd_b_idx_i (upd_idx),
    .rd_b_ctr_o (old_ctr),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_idx),
    .wr_ctr_i   (new_ctr)
  );

  sat_ctr_step #(.CTR_W(CTR_W)) i_step (
    .ctr_i (old_ctr),
    .dir_i (upd_dir),
    .ctr_o (new_ctr)
  );

  // threshold 2^(CTR_W-1) is the counter MSB
  assign lookup_taken_o = rd_ctr[CTR_W-1];
endmodule

// File: rtl/sat_ctr_predictor_chk.sv
module sat_ctr_predictor_chk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6,
  parameter int CTR_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] lookup_addr_i,
  input logic              lookup_taken_o,
  input logic              upd_valid_i,
  input logic [ADDR_W-1:0] upd_addr_i,
  input logic              upd_taken_i,
  input logic [CTR_W-1:0]  rd_ctr
);
  localparam logic [CTR_W-1:0] CTR_MAX = '1;
  logic same_idx;
  assign same_idx = lookup_addr_i[IDX_W-1:0] == upd_addr_i[IDX_W-1:0];

  assert_idle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> (!$stable(lookup_addr_i) || $stable(lookup_taken_o)));

  assert_other_entry_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !same_idx) |=> (!$stable(lookup_addr_i) || $stable(lookup_taken_o)));

  assert_sat_high_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && same_idx && rd_ctr == CTR_MAX)
      |=> (!$stable(lookup_addr_i) || rd_ctr == CTR_MAX));

  assert_sat_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && same_idx && rd_ctr == '0)
      |=> (!$stable(lookup_addr_i) || rd_ctr == '0));

  assert_pre_update_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i && same_idx && rd_ctr != CTR_MAX)
      |=> (!$stable(lookup_addr_i) || rd_ctr == $past(rd_ctr) + CTR_W'(1)));

  assert_dec_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && !upd_taken_i && same_idx && rd_ctr != '0)
      |=> (!$stable(lookup_addr_i) || rd_ctr == $past(rd_ctr) - CTR_W'(1)));
endmodule

bind sat_ctr_predictor sat_ctr_predictor_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTR_W(CTR_W)
) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lookup_addr_i  (lookup_addr_i),
  .lookup_taken_o (lookup_taken_o),
  .upd_valid_i    (upd_valid_i),
  .upd_addr_i     (upd_addr_i),
  .upd_taken_i    (upd_taken_i),
  .rd_ctr         (rd_ctr)
);

// File: tb/test_sat_ctr_predictor.sv
module test_sat_ctr_predictor;
  localparam int ADDR_W  = 32;
  localparam int IDX_W   = 6;
  localparam int CTR_W   = 2;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int MAXV    = (1 << CTR_W) - 1;
  localparam int HALF    = 1 << (CTR_W - 1);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] lookup_addr = '0;
  logic              lookup_taken;
  logic              upd_valid = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0;
  logic              upd_taken = 1'b0;

  int  model [ENTRIES];
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  sat_ctr_predictor #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CTR_W(CTR_W)) i_sat_ctr_predictor (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .lookup_addr_i  (lookup_addr),
    .lookup_taken_o (lookup_taken),
    .upd_valid_i    (upd_valid),
    .upd_addr_i     (upd_addr),
    .upd_taken_i    (upd_taken)
  );

  function automatic int idx_of(logic [ADDR_W-1:0] a);
    return int'(a[IDX_W-1:0]);
  endfunction

  function automatic bit exp_pred(logic [ADDR_W-1:0] a);
    return model[idx_of(a)] >= HALF;
  endfunction

  function automatic int sat_move(int v, bit t);
    if (t) return (v == MAXV) ? v : v + 1;
    return (v == 0) ? v : v - 1;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lookup_taken actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // drive at falling edge, compare combinational output, advance model after rising edge
  task automatic step(logic [ADDR_W-1:0] la, bit uv, logic [ADDR_W-1:0] ua, bit ut, string req,
                      output bit pred);
    @(negedge clk);
    lookup_addr = la; upd_valid = uv; upd_addr = ua; upd_taken = ut;
    #1;
    pred = lookup_taken;
    check(req, lookup_taken, exp_pred(la));
    @(posedge clk);
    if (uv) model[idx_of(ua)] = sat_move(model[idx_of(ua)], ut);
  endtask

  task automatic upd(logic [ADDR_W-1:0] a, bit t, string req);
    bit p;
    step(a, 1'b1, a, t, req, p);
  endtask

  task automatic look(logic [ADDR_W-1:0] a, logic exp, string req);
    bit p;
    step(a, 1'b0, '0, 1'b0, req, p);
    check(req, p, exp);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: all requirements, actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit p;
    int miss;
    void'($urandom(32'd20240611));
    for (int i = 0; i < ENTRIES; i++) model[i] = HALF - 1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R3 reset state: every entry predicts not-taken
    for (int i = 0; i < ENTRIES; i++) look(ADDR_W'(i), 1'b0, "R3");
    upd(32'd3, 1'b1, "R3");
    look(32'd3, 1'b1, "R3");

    // R1 aliasing: high address bits are ignored
    upd(32'h0001_0005, 1'b1, "R1");
    look(32'hABCD_0005, 1'b1, "R1");

    // R6 update with valid low is ignored
    step(32'd7, 1'b0, 32'd7, 1'b1, "R6", p);
    look(32'd7, 1'b0, "R6");

    // R7 same-cycle lookup sees the old value
    step(32'd9, 1'b1, 32'd9, 1'b1, "R7", p);
    check("R7", p, 1'b0);
    look(32'd9, 1'b1, "R7");

    // R8 neighbour untouched
    upd(32'd10, 1'b1, "R8");
    upd(32'd10, 1'b1, "R8");
    look(32'd11, 1'b0, "R8");

    // R4 saturate high then two decrements: 3 -> 2 (taken) -> 1 (not)
    repeat (5) upd(32'd12, 1'b1, "R4");
    upd(32'd12, 1'b0, "R4");
    look(32'd12, 1'b1, "R4");
    upd(32'd12, 1'b0, "R4");
    look(32'd12, 1'b0, "R4");

    // R5 saturate low then increments: 0 -> 1 (not) -> 2 (taken)
    repeat (5) upd(32'd13, 1'b0, "R5");
    upd(32'd13, 1'b1, "R5");
    look(32'd13, 1'b0, "R5");
    upd(32'd13, 1'b1, "R5");
    look(32'd13, 1'b1, "R2");

    // R9 loop branch: T,T,T,T,N per pass; one miss per pass after the first
    for (int pass = 0; pass < 3; pass++) begin
      miss = 0;
      for (int k = 0; k < 5; k++) begin
        step(32'h400 + 32'd50, 1'b1, 32'h400 + 32'd50, (k != 4), "R9", p);
        if (p != (k != 4)) miss++;
      end
      if (pass > 0) check("R9", logic'(miss == 1), 1'b1);
    end

    // random traffic over a few entries, colliding lookups and updates
    for (int n = 0; n < 3000; n++) begin
      logic [ADDR_W-1:0] la, ua;
      la = {ADDR_W'($urandom) & 32'hFFFF_FFC0} | ADDR_W'($urandom_range(0, 7));
      ua = ($urandom_range(0, 3) == 0) ? la
         : ({ADDR_W'($urandom) & 32'hFFFF_FFC0} | ADDR_W'($urandom_range(0, 7)));
      step(la, bit'($urandom_range(0, 1)), ua, bit'($urandom_range(0, 1)), "R2", p);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule